// File: doc/BRIEF.md
# Bus Clock Enable Controller

This block derives a bus-clock enable strobe from the single CPU clock. No clock is divided or switched. Every clock is modelled as a one-cycle enable in the CPU clock domain. A static speed strap selects 1:1 operation, where the bus runs at the CPU rate, or 2:1 operation. In 2:1 operation the bus rate follows each access: accesses to external memory run at half rate, and accesses to internal RAM/ROM run at full rate.

The block also times each access. An access starts with a request and an area class. It ends with a one-cycle done pulse. The length of an internal I/O access depends on the speed mode and on a short/long select input. A standby code stops the bus enable in the deep halt and sleep modes and keeps it running in basic halt, so that refresh can continue. A select field picks which of five clock enables appears on the external bus clock output.

Top module: `bus_clk_enable_ctrl`

## Requirements
- R1: With `x1_mode`=1, `bclk_en` is high in every running cycle, a memory access (`area` 00 = internal RAM/ROM, 1x = external) lasts MEM_BCLKS (default 2) cycles, and `done` is high in its last cycle.
- R2: With `x1_mode`=0, an external access (`area`=1x) lasts 2*MEM_BCLKS cycles, and `bclk_en` is high in its first cycle and in every second cycle after that (pattern 1,0,1,0).
- R3: With `x1_mode`=0, an internal RAM/ROM access (`area`=00) lasts MEM_BCLKS cycles, with `bclk_en` high in every cycle.
- R4: With `x1_mode`=1, an internal I/O access (`area`=01) lasts IO_LONG (4) cycles, whatever `io_short` is.
- R5: With `x1_mode`=0, an internal I/O access lasts IO_SHORT (2) cycles when `io_short`=1 and IO_LONG (4) cycles when `io_short`=0. `bclk_en` stays at full rate.
- R6: `standby` 00 = run and 01 = basic halt: the bus enable runs and accesses complete. `standby` 10 or 11 = stopped: `bclk_en` and `done` are low, and the access count is frozen.
- R7: `done` is high for exactly one cycle. The cycle is counted from the cycle after the clock edge at which `req` is accepted.
- R8: `req` is ignored while an access is in progress (this includes its done cycle) and while the bus is stopped. A request held high is therefore accepted one idle cycle after `done`.
- R9: `x1_mode`, `io_short`, `sdram_en` and `out_sel` are taken only while no access is in progress. A change made during an access affects only later accesses.
- R10: `out_en` follows the selection registered from the last idle cycle. If `sdram_en`=1 it shows `sd_en`. Otherwise `out_sel` 11 shows `pll_en`, 10 shows `osc_en`, 01 shows `bclk_en`, and 00 shows the CPU enable, which is high only when `standby`=00.
- R11: When the bus leaves a stopped standby mode during a half-rate access, the first cycle has `bclk_en` high and the remaining length is counted again from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| x1_mode | input | 1 | Speed strap: 1 = 1:1, 0 = 2:1 |
| io_short | input | 1 | I/O length select used in 2:1 mode |
| req | input | 1 | Access request |
| area | input | 2 | Area class: 00 RAM/ROM, 01 I/O, 1x external |
| standby | input | 2 | 00 run, 01 basic halt, 10 deep halt, 11 sleep |
| sdram_en | input | 1 | Forces the SDRAM clock onto the output |
| out_sel | input | 2 | Output clock source select |
| pll_en | input | 1 | PLL clock enable source |
| osc_en | input | 1 | Oscillator clock enable source |
| sd_en | input | 1 | SDRAM clock enable source |
| bclk_en | output | 1 | Bus clock enable |
| done | output | 1 | Access complete, one cycle |
| out_en | output | 1 | Selected enable for the external clock pin |

## Verification
Two functions can land on the same edge.

The first case is standby entry and half-rate stepping. The bench stops the bus one cycle into an external 2:1 access and keeps a request high while the bus is stopped. It then releases standby. It judges the result by checking that the enable restarts high and that `done` comes exactly four cycles later.

The second case is the done cycle and a new request. The bench holds `req` high across an access. It then checks that `done` stays low for exactly the idle cycle and the first cycle of the next access, and rises again after that.

// File: rtl/bus_clk_enable_ctrl.sv
module bus_clk_enable_ctrl #(
  parameter int MEM_BCLKS = 2,
  parameter int IO_LONG   = 4,
  parameter int IO_SHORT  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       x1_mode,
  input  logic       io_short,
  input  logic       req,
  input  logic [1:0] area,
  input  logic [1:0] standby,
  input  logic       sdram_en,
  input  logic [1:0] out_sel,
  input  logic       pll_en,
  input  logic       osc_en,
  input  logic       sd_en,
  output logic       bclk_en,
  output logic       done,
  output logic       out_en
);
  localparam int MEM_HALF = 2 * MEM_BCLKS;
  localparam int MAX_A    = (IO_LONG > IO_SHORT) ? IO_LONG : IO_SHORT;
  localparam int MAX_LEN  = (MAX_A > MEM_HALF) ? MAX_A : MEM_HALF;
  localparam int CW       = $clog2(MAX_LEN + 1);

  logic          stop, busy, ph, half_q, sdr_q, accept;
  logic [1:0]    sel_q;
  logic [CW-1:0] cnt, last, len_m1;

  assign stop   = standby[1];
  assign accept = req && !busy && !stop;

  always_comb begin
    if (area == 2'b01)
      len_m1 = (!x1_mode && io_short) ? CW'(IO_SHORT - 1) : CW'(IO_LONG - 1);
    else if (area[1] && !x1_mode)
      len_m1 = CW'(MEM_HALF - 1);
    else
      len_m1 = CW'(MEM_BCLKS - 1);
  end

  assign done    = busy && !stop && (cnt == last);
  assign bclk_en = !stop && !(busy && half_q && ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      last   <= '0;
      ph     <= 1'b0;
      half_q <= 1'b0;
      sdr_q  <= 1'b0;
      sel_q  <= 2'b00;
    end else begin
      if (!busy) begin
        sdr_q <= sdram_en;
        sel_q <= out_sel;
      end
      if (stop) begin
        ph <= 1'b0;
      end else if (accept) begin
        busy   <= 1'b1;
        cnt    <= '0;
        last   <= len_m1;
        ph     <= 1'b0;
        half_q <= area[1] && !x1_mode;
      end else if (done) begin
        busy <= 1'b0;
        ph   <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        ph  <= ~ph;
      end
    end
  end

  always_comb begin
    if (sdr_q) out_en = sd_en;
    else begin
      case (sel_q)
        2'b11:   out_en = pll_en;
        2'b10:   out_en = osc_en;
        2'b01:   out_en = bclk_en;
        default: out_en = (standby == 2'b00);
      endcase
    end
  end
endmodule

// File: rtl/bus_clk_enable_ctrl_chk.sv
module bus_clk_enable_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop,
  input logic       busy,
  input logic       half_q,
  input logic       req,
  input logic       bclk_en,
  input logic       done,
  input logic [1:0] sel_q
);
  p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> (!bclk_en && !done));

  p_stopped_no_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy) |=> !busy);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_half_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half_q && bclk_en && !done && !stop) |=> !bclk_en);

  p_accept_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req) && !$past(stop)));

  p_sel_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_q));
endmodule

bind bus_clk_enable_ctrl bus_clk_enable_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .busy(busy), .half_q(half_q),
  .req(req), .bclk_en(bclk_en), .done(done), .sel_q(sel_q)
);

// File: tb/tb_bus_clk_enable_ctrl.sv
module tb_bus_clk_enable_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic x1_mode = 1'b1, io_short = 1'b0, req = 1'b0;
  logic [1:0] area = 2'b00, standby = 2'b00, out_sel = 2'b01;
  logic sdram_en = 1'b0, pll_en = 1'b0, osc_en = 1'b0, sd_en = 1'b0;
  logic bclk_en, done, out_en;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  bus_clk_enable_ctrl dut (
    .clk(clk), .rst_n(rst_n), .x1_mode(x1_mode), .io_short(io_short), .req(req),
    .area(area), .standby(standby), .sdram_en(sdram_en), .out_sel(out_sel),
    .pll_en(pll_en), .osc_en(osc_en), .sd_en(sd_en),
    .bclk_en(bclk_en), .done(done), .out_en(out_en)
  );

  // {x1_mode, area, io_short, length, bclk pattern (bit k = cycle k)}
  localparam logic [11:0] VEC [0:8] = '{
    12'b1_00_0_0010_0011, 12'b1_10_0_0010_0011, 12'b1_01_0_0100_1111,
    12'b1_01_1_0100_1111, 12'b0_00_0_0010_0011, 12'b0_11_0_0100_0101,
    12'b0_01_1_0010_0011, 12'b0_01_0_0100_1111, 12'b0_10_1_0100_0101
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic m, input logic [1:0] a, input logic s,
                            output int n, output logic [7:0] p);
    @(negedge clk); x1_mode = m; area = a; io_short = s; req = 1'b1;
    @(negedge clk); req = 1'b0; p = '0; n = 0;
    for (int k = 0; k < 8; k++) begin
      p[k] = bclk_en;
      if (done) begin n = k + 1; break; end
      if (k < 7) @(negedge clk);
    end
  endtask

  task automatic set_sel(input logic sdr, input logic [1:0] s);
    @(negedge clk); sdram_en = sdr; out_sel = s;
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] p;
    string tag;
    @(negedge clk);
    check("R1 reset bclk_en", int'(bclk_en), 1);
    check("R7 reset done", int'(done), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < 9; v++) begin
      run_access(VEC[v][11], VEC[v][10:9], VEC[v][8], n, p);
      if (VEC[v][11]) tag = (VEC[v][10:9] == 2'b01) ? "R4" : "R1";
      else if (VEC[v][10:9] == 2'b01) tag = "R5";
      else tag = VEC[v][10] ? "R2" : "R3";
      check({tag, " length"}, n, int'(VEC[v][7:4]));
      check({tag, " bclk pattern"}, int'(p[3:0]), int'(VEC[v][3:0]));
    end

    // R6 basic halt keeps running
    standby = 2'b01;
    run_access(1'b1, 2'b00, 1'b0, n, p);
    check("R6 halt length", n, 2);
    check("R6 halt pattern", int'(p[3:0]), 3);
    @(negedge clk); standby = 2'b00;

    // R6/R11 stop during half-rate access, then wake
    @(negedge clk); x1_mode = 1'b0; area = 2'b10; req = 1'b1;
    @(negedge clk); req = 1'b0;
    check("R2 first cycle high", int'(bclk_en), 1);
    standby = 2'b10; req = 1'b1; #1;
    check("R6 stop bclk", int'(bclk_en), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 stopped bclk", int'(bclk_en), 0);
      check("R6 stopped done", int'(done), 0);
    end
    req = 1'b0; standby = 2'b00; #1;
    check("R11 wake phase 0", int'(bclk_en), 1);
    @(negedge clk); check("R11 wake c1", int'(bclk_en), 0);
    @(negedge clk); check("R11 wake c2", int'(bclk_en), 1);
    check("R11 no early done", int'(done), 0);
    @(negedge clk); check("R11 wake c3 done", int'(done), 1);

    // R8 request while stopped and idle is dropped
    @(negedge clk); standby = 2'b11; req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); check("R8 stopped req", int'(done), 0);
    end
    req = 1'b0; standby = 2'b00;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); check("R8 no late access", int'(done), 0);
    end

    // R7/R8 held request
    @(negedge clk); x1_mode = 1'b1; area = 2'b00; req = 1'b1;
    @(negedge clk); check("R7 c0", int'(done), 0);
    @(negedge clk); check("R7 c1 done", int'(done), 1);
    @(negedge clk); check("R8 idle gap", int'(done), 0);
    @(negedge clk); check("R8 restart c0", int'(done), 0);
    @(negedge clk); check("R8 second done", int'(done), 1);
    req = 1'b0;

    // R9 config changes during access
    set_sel(1'b0, 2'b01);
    @(negedge clk); x1_mode = 1'b0; area = 2'b10; req = 1'b1;
    @(negedge clk); req = 1'b0; x1_mode = 1'b1; sdram_en = 1'b1; sd_en = 1'b1;
    @(negedge clk);
    check("R9 half rate kept", int'(bclk_en), 0);
    check("R9 old select kept", int'(out_en), 0);
    @(negedge clk); @(negedge clk);
    check("R9 length kept", int'(done), 1);
    @(negedge clk); @(negedge clk);
    check("R9 new select used", int'(out_en), 1);

    // R10 output source selection
    sd_en = 1'b0; #1; check("R10 sdram 0", int'(out_en), 0);
    set_sel(1'b0, 2'b11);
    pll_en = 1'b1; #1; check("R10 pll 1", int'(out_en), 1);
    pll_en = 1'b0; #1; check("R10 pll 0", int'(out_en), 0);
    set_sel(1'b0, 2'b10);
    osc_en = 1'b1; #1; check("R10 osc 1", int'(out_en), 1);
    osc_en = 1'b0; #1; check("R10 osc 0", int'(out_en), 0);
    set_sel(1'b0, 2'b01);
    check("R10 bus clk running", int'(out_en), 1);
    standby = 2'b10; #1; check("R10 bus clk stopped", int'(out_en), 0);
    standby = 2'b00;
    set_sel(1'b0, 2'b00);
    check("R10 cpu run", int'(out_en), 1);
    standby = 2'b01; #1; check("R10 cpu halt", int'(out_en), 0);
    standby = 2'b00;
    set_sel(1'b1, 2'b11);
    pll_en = 1'b1; sd_en = 1'b0; #1; check("R10 sdram overrides", int'(out_en), 0);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule